// File: doc/BRIEF.md
# DDR DLL Relock Sequencer

This controller-side block brings a DDR device's delay-locked loop into a known state and keeps reads back until the loop has had time to settle. A single request pulse carries the chosen settings: DLL on or off, reduced or normal output drive, the base mode word, and whether the request follows a self-refresh exit. The block waits until every bank is idle and no burst is running. It then issues a load of the extended mode register. When the DLL is being turned on, it follows with a load of the base mode register that has the DLL-reset bit set. It then counts clock cycles with clock enable high and raises a read-permitted flag at the end of that count.

After a self-refresh exit the DLL comes back on by itself. For that case the extended load is skipped and only the DLL-reset load and the lock window are run. Commands use the usual active-low row/column/write-enable triple: `000` is a mode-register load and `111` is a no-operation. The surrounding controller muxes these lines onto the command bus while `busy_o` is high and holds off READs until `read_ok_o` is set.

Top module: `ddr_dll_relock_seq`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of a sequence, `cmd_o` is `111` (no-op), `ba_o` and `addr_o` are zero, and `busy_o` and `read_ok_o` are low.
- R2: For a DLL-on request that is accepted while `banks_idle_i` is high, an extended load is driven in the cycle after the accepting edge. It has `cmd_o`=`000` and `ba_o`=`01`. `addr_o` bit 0 carries the DLL-off choice (0 = on), bit 1 carries the drive choice (0 = normal, 1 = reduced), and every higher address bit is 0.
- R3: In a DLL-on sequence, a base load follows the extended load exactly GAP cycles later (default 2). It has `cmd_o`=`000` and `ba_o`=`00`, and `addr_o` equals the captured base mode word with bit 8 (the DLL reset) forced to 1. The cycles between the two loads are no-ops.
- R4: When clock enable stays high, `read_ok_o` rises exactly LOCK cycles after the cycle that carries the base load (default 200). The base-load cycle counts as the first of those cycles.
- R5: The lock count advances only on cycles where `cke_i` is high. Each low cycle inside the window delays `read_ok_o` by one cycle, and the count already reached is kept, not restarted.
- R6: A request accepted while `banks_idle_i` is low is held. No load is issued until `banks_idle_i` is sampled high, and the first load appears in the cycle after that edge.
- R7: `busy_o` is high from the accepting edge until `read_ok_o` rises, and it is never high at the same time as `read_ok_o`. A request made while busy is ignored: no extra load is issued, the timing does not change, and the settings already captured are kept.
- R8: A request flagged as a self-refresh exit issues no extended load. Its base load (with the DLL reset bit set) appears where the extended load would otherwise have appeared, and the LOCK window follows it.
- R9: A DLL-off request (not a self-refresh exit) issues only the extended load, with address bit 0 = 1. It issues no base load, and `read_ok_o` rises GAP cycles after that load.
- R10: `read_ok_o` drops on the edge that accepts a new request.
- R11: In every cycle that is not a load, `cmd_o` is `111` and `ba_o` and `addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted when not busy |
| sr_exit_i | input | 1 | Request follows a self-refresh exit (skip the extended load) |
| dll_off_i | input | 1 | Request turns the DLL off instead of on |
| drive_red_i | input | 1 | Select reduced output drive |
| base_mode_i | input | ADDR_W | Base mode word to load with the DLL reset |
| banks_idle_i | input | 1 | All banks idle and no burst in progress |
| cke_i | input | 1 | Clock enable currently high at the device |
| cmd_o | output | 3 | Active-low row/column/write-enable command |
| ba_o | output | 2 | Bank address of the command |
| addr_o | output | ADDR_W | Address lines of the command |
| busy_o | output | 1 | Sequence in progress |
| read_ok_o | output | 1 | READ commands allowed |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts the request, or from the edge that first sees the banks idle. The first load is due in the cycle after that edge, the base load GAP cycles after the extended load, and `read_ok_o` LOCK cycles after the base load plus one cycle for each low clock-enable sample. The bench keeps a cycle counter, samples every output on the falling edge, and records the cycle of each load and of the rise of read-permitted. It then compares those cycles as offsets from acceptance against the values it computes from the requirements.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

    // Active-low {ras_n, cas_n, we_n} command encodings used by this block
    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_NOP = 3'b111
    } cmd_e;

    // Bank-address selections of the two mode registers
    localparam logic [1:0] BA_BASE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_EXT_GAP,
        ST_OFF_GAP,
        ST_LOCK
    } state_e;

    typedef enum logic [1:0] {
        ISS_NONE,
        ISS_EXT,
        ISS_BASE
    } issue_e;

    // Settings captured when a request is accepted
    typedef struct packed {
        logic sr_exit;
        logic dll_off;
        logic drive_red;
    } req_cfg_t;

    // The extended load is skipped after self refresh: the DLL returns on its own
    function automatic logic needs_ext(input req_cfg_t c);
        return !c.sr_exit;
    endfunction

    // An extended load that turns the DLL off ends the sequence without a reset load
    function automatic logic ends_after_ext(input req_cfg_t c);
        return !c.sr_exit && c.dll_off;
    endfunction

endpackage

// File: rtl/dllseq_gap_timer.sv
module dllseq_gap_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic zero_o
);
    localparam int CW = (GAP < 2) ? 1 : $clog2(GAP + 1);
    localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    p_gap_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= RELOAD);

endmodule

// File: rtl/dllseq_lock_timer.sv
module dllseq_lock_timer #(
    parameter int LOCK = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    input  logic cke_i,
    output logic done_o
);
    localparam int CW = (LOCK < 2) ? 1 : $clog2(LOCK);
    localparam logic [CW-1:0] LAST = CW'(LOCK - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = run_i && cke_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && cke_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: a low clock enable freezes the window count
    p_cke_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (run_i && !cke_i && !clear_i) |=> $stable(cnt_q));

    // R4: the count never passes the window end
    p_lock_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/dllseq_cmd_drive.sv
module dllseq_cmd_drive
    import dllseq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int RST_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  issue_e            issue_i,
    input  logic              dll_off_i,
    input  logic              drive_red_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [2:0]        cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] RST_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << RST_BIT;

    cmd_e              nxt_cmd;
    logic [1:0]        nxt_ba;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb begin
        nxt_cmd  = CMD_NOP;
        nxt_ba   = '0;
        nxt_addr = '0;
        case (issue_i)
            ISS_EXT: begin
                nxt_cmd     = CMD_LMR;
                nxt_ba      = BA_EXT;
                nxt_addr[0] = dll_off_i;
                nxt_addr[1] = drive_red_i;
            end
            ISS_BASE: begin
                nxt_cmd  = CMD_LMR;
                nxt_ba   = BA_BASE;
                nxt_addr = base_i | RST_MASK;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o  <= CMD_NOP;
            ba_o   <= '0;
            addr_o <= '0;
        end else begin
            cmd_o  <= nxt_cmd;
            ba_o   <= nxt_ba;
            addr_o <= nxt_addr;
        end
    end

    p_ext_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_LMR && ba_o == BA_EXT) |-> (addr_o[ADDR_W-1:2] == '0));

    p_base_dll_reset_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_LMR && ba_o == BA_BASE) |-> addr_o[RST_BIT]);

    p_nop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_LMR) |-> (cmd_o == CMD_NOP && ba_o == '0 && addr_o == '0));

endmodule

// File: rtl/ddr_dll_relock_seq.sv
module ddr_dll_relock_seq
    import dllseq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int GAP     = 2,
    parameter int LOCK    = 200,
    parameter int RST_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sr_exit_i,
    input  logic              dll_off_i,
    input  logic              drive_red_i,
    input  logic [ADDR_W-1:0] base_mode_i,
    input  logic              banks_idle_i,
    input  logic              cke_i,
    output logic [2:0]        cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              read_ok_o
);
    state_e            st_q, st_d;
    req_cfg_t          cfg_q, cfg_now;
    logic [ADDR_W-1:0] base_q, base_now;
    issue_e            issue;
    logic              accept, waiting, finish;
    logic              gap_zero, lock_done;

    always_comb begin
        accept  = (st_q == ST_IDLE) && start_i;
        waiting = accept || (st_q == ST_PEND);
        if (accept) begin
            cfg_now.sr_exit   = sr_exit_i;
            cfg_now.dll_off   = dll_off_i;
            cfg_now.drive_red = drive_red_i;
            base_now          = base_mode_i;
        end else begin
            cfg_now  = cfg_q;
            base_now = base_q;
        end
    end

    always_comb begin
        st_d   = st_q;
        issue  = ISS_NONE;
        finish = 1'b0;
        case (st_q)
            ST_IDLE, ST_PEND: begin
                if (waiting) begin
                    if (!banks_idle_i) begin
                        st_d = ST_PEND;
                    end else if (needs_ext(cfg_now)) begin
                        issue = ISS_EXT;
                        st_d  = ends_after_ext(cfg_now) ? ST_OFF_GAP : ST_EXT_GAP;
                    end else begin
                        issue = ISS_BASE;
                        st_d  = ST_LOCK;
                    end
                end
            end
            ST_EXT_GAP: begin
                if (gap_zero) begin
                    issue = ISS_BASE;
                    st_d  = ST_LOCK;
                end
            end
            ST_OFF_GAP: begin
                if (gap_zero) begin
                    finish = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            ST_LOCK: begin
                if (lock_done) begin
                    finish = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cfg_q     <= '0;
            base_q    <= '0;
            busy_o    <= 1'b0;
            read_ok_o <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                cfg_q     <= cfg_now;
                base_q    <= base_now;
                busy_o    <= 1'b1;
                read_ok_o <= 1'b0;
            end
            if (finish) begin
                busy_o    <= 1'b0;
                read_ok_o <= 1'b1;
            end
        end
    end

    dllseq_gap_timer #(
        .GAP(GAP)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load_i (issue == ISS_EXT),
        .zero_o (gap_zero)
    );

    dllseq_lock_timer #(
        .LOCK(LOCK)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .clear_i (issue == ISS_BASE),
        .run_i   (st_q == ST_LOCK),
        .cke_i   (cke_i),
        .done_o  (lock_done)
    );

    dllseq_cmd_drive #(
        .ADDR_W  (ADDR_W),
        .RST_BIT (RST_BIT)
    ) u_drive (
        .clk         (clk),
        .rst         (rst),
        .issue_i     (issue),
        .dll_off_i   (cfg_now.dll_off),
        .drive_red_i (cfg_now.drive_red),
        .base_i      (base_now),
        .cmd_o       (cmd_o),
        .ba_o        (ba_o),
        .addr_o      (addr_o)
    );

    // R6: an extended load only follows an edge that saw idle banks
    p_ext_needs_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_LMR && ba_o == BA_EXT) |-> $past(banks_idle_i));

    p_busy_excl_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !read_ok_o);

    p_load_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_LMR) |-> busy_o);

    p_ok_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(read_ok_o) |-> $past(busy_o));

endmodule

// File: tb/ddr_dll_relock_seq_bench.sv
`timescale 1ns/1ps
module ddr_dll_relock_seq_bench;

    localparam int ADDR_W  = 13;
    localparam int GAP     = 2;
    localparam int LOCK    = 200;
    localparam int RST_BIT = 8;
    localparam logic [ADDR_W-1:0] RST_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << RST_BIT;

    typedef struct packed {
        logic       sr;
        logic       off;
        logic       drv;
        logic [12:0] base;
        logic [7:0] idle_dly;
        logic [7:0] cke_low;
        logic       poke;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 13'h0032, 8'd0, 8'd0, 1'b0},   // R2 R3 R4 plain enable
        '{1'b0, 1'b0, 1'b1, 13'h0062, 8'd4, 8'd0, 1'b0},   // R6 pending, reduced drive
        '{1'b0, 1'b0, 1'b0, 13'h0000, 8'd0, 8'd7, 1'b0},   // R5 clock enable gaps
        '{1'b0, 1'b1, 1'b1, 13'h0044, 8'd2, 8'd0, 1'b0},   // R9 DLL off
        '{1'b1, 1'b0, 1'b1, 13'h0022, 8'd3, 8'd3, 1'b0},   // R8 self-refresh exit
        '{1'b0, 1'b0, 1'b0, 13'h01FF, 8'd0, 8'd0, 1'b1}    // R7 request while busy
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, sr = 1'b0, off = 1'b0, drv = 1'b0;
    logic idle = 1'b0, cke = 1'b1;
    logic [ADDR_W-1:0] base = '0;
    logic [2:0] cmd;
    logic [1:0] ba;
    logic [ADDR_W-1:0] addr;
    logic busy, rok;
    int cyc = 0, n_chk = 0, n_err = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr_dll_relock_seq #(
        .ADDR_W(ADDR_W), .GAP(GAP), .LOCK(LOCK), .RST_BIT(RST_BIT)
    ) u_ddr_dll_relock_seq (
        .clk(clk), .rst(rst), .start_i(start), .sr_exit_i(sr), .dll_off_i(off),
        .drive_red_i(drv), .base_mode_i(base), .banks_idle_i(idle), .cke_i(cke),
        .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .busy_o(busy), .read_ok_o(rok)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string what);
        chk(cmd === 3'b111, "R1", {what, " cmd"}, int'(cmd), 7);
        chk(ba === 2'b00 && addr === '0, "R1", {what, " ba/addr"}, int'(addr), 0);
        chk(busy === 1'b0, "R1", {what, " busy"}, int'(busy), 0);
        chk(rok === 1'b0, "R1", {what, " read_ok"}, int'(rok), 0);
    endtask

    task automatic run_vec(input vec_t v);
        int t_acc, emr_c, mr_c, ok_c, n_lmr, nop_bad, busy_bad;
        int emr_exp, mr_exp, ok_exp, lmr_exp;
        logic [ADDR_W-1:0] emr_a, mr_a, emr_exp_a;
        logic [1:0] mr_b;
        bit done;
        emr_c = -1; mr_c = -1; ok_c = -1; n_lmr = 0; nop_bad = 0; busy_bad = 0;
        done = 0; emr_a = '0; mr_a = '0; mr_b = '0;
        @(negedge clk);
        start = 1'b1; sr = v.sr; off = v.off; drv = v.drv; base = v.base;
        idle = (v.idle_dly == 0); cke = 1'b1;
        @(negedge clk);
        start = 1'b0; sr = 1'b0; off = 1'b0; drv = 1'b0; base = '0;
        t_acc = cyc;
        chk(busy === 1'b1, "R7", "busy after accept", int'(busy), 1);
        chk(rok === 1'b0, "R10", "read_ok after accept", int'(rok), 0);
        emr_exp   = v.sr ? -1 : t_acc + int'(v.idle_dly);
        mr_exp    = v.sr ? t_acc + int'(v.idle_dly)
                         : (v.off ? -1 : t_acc + int'(v.idle_dly) + GAP);
        ok_exp    = (v.off && !v.sr) ? emr_exp + GAP : mr_exp + LOCK + int'(v.cke_low);
        lmr_exp   = (v.sr || v.off) ? 1 : 2;
        emr_exp_a = {{(ADDR_W-2){1'b0}}, v.drv, v.off};
        for (int k = 0; k < 2000 && !done; k++) begin
            if (k > 0) @(negedge clk);
            if (cmd == 3'b000) begin
                n_lmr++;
                if (ba == 2'b01) begin
                    emr_c = cyc; emr_a = addr;
                end else begin
                    mr_c = cyc; mr_a = addr; mr_b = ba;
                end
            end else if (ba != 2'b00 || addr != '0 || cmd != 3'b111) begin
                nop_bad++;
            end
            if (rok) begin
                ok_c = cyc; done = 1;
            end else if (!busy) begin
                busy_bad++;
            end
            idle  = ((k + 1) >= int'(v.idle_dly));
            cke   = !(mr_exp >= 0 && cyc + 1 >= mr_exp + 5 &&
                      cyc + 1 < mr_exp + 5 + int'(v.cke_low));
            start = v.poke && k == 4;
            sr    = v.poke && k == 4;
            off   = v.poke && k == 4;
            drv   = v.poke && k == 4;
            base  = (v.poke && k == 4) ? '1 : '0;
        end
        start = 1'b0; sr = 1'b0; off = 1'b0; drv = 1'b0; base = '0; cke = 1'b1;
        chk(done, "R4", "read_ok reached", int'(done), 1);
        chk(ok_c == ok_exp, (v.cke_low != 0) ? "R5" : ((v.off && !v.sr) ? "R9" : "R4"),
            "read_ok offset", ok_c - t_acc, ok_exp - t_acc);
        if (v.sr) begin
            chk(emr_c == -1, "R8", "no extended load", emr_c, -1);
        end else begin
            chk(emr_c == emr_exp, (v.idle_dly != 0) ? "R6" : "R2", "extended load offset",
                emr_c - t_acc, emr_exp - t_acc);
            chk(emr_a == emr_exp_a, "R2", "extended load address", int'(emr_a), int'(emr_exp_a));
        end
        if (v.off && !v.sr) begin
            chk(mr_c == -1, "R9", "no base load", mr_c, -1);
        end else begin
            chk(mr_c == mr_exp, v.sr ? "R8" : "R3", "base load offset",
                mr_c - t_acc, mr_exp - t_acc);
            chk(mr_a == (v.base | RST_MASK), "R3", "base load address",
                int'(mr_a), int'(v.base | RST_MASK));
            chk(mr_b == 2'b00, "R3", "base load bank", int'(mr_b), 0);
        end
        chk(n_lmr == lmr_exp, "R7", "load count", n_lmr, lmr_exp);
        chk(nop_bad == 0, "R11", "non-load cycles quiet", nop_bad, 0);
        chk(busy_bad == 0, "R7", "busy held until read_ok", busy_bad, 0);
        @(negedge clk);
        chk(busy === 1'b0 && rok === 1'b1, "R7", "idle after completion",
            int'({busy, rok}), 1);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_reset_state("after reset");

        // R1: reset in the middle of a lock window
        start = 1'b1; idle = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_reset_state("reset mid-sequence");
        rst = 1'b0;
        @(negedge clk);
        chk_reset_state("after mid reset");

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule